// File: doc/BRIEF.md
# Router Board I/O Register Decoder

This block is the board-level register file that a router's CPU reaches through a simple read/write bus with 16-bit data. It decodes a byte offset into a set of registers:
- a fixed platform identity word;
- three bit-banged serial EEPROM ports, one for the mainboard and one for each of two module slots;
- active-low presence words for the module slots and the flash cards;
- a read/write interrupt mask;
- a set of constant status words.

Read data is a combinational function of the offset and the block's state. Writes take effect on the next rising clock edge.

The network interrupt status register does not use write-one-to-clear. A rising source input sets the network interrupt output. Reads of the status offset advance a counter, and when that counter has seen a fixed number of reads, the output drops. Every presence indication reads as zero when the item is fitted. The EEPROM device, the CPU and the interrupt controller sit outside this block.

Top module: `board_io_regs`

## Requirements
- R1: A read of offset 0x36 returns the platform word 0x0080, which is the code 4 placed at bits 7:5.
- R2: A write to offset 0x0E loads the mainboard EEPROM pins from the written data: chip select from bit 0, clock from bit 1 and data-in from bit 2. These registered pins hold their value until the next write to 0x0E.
- R3: A read of offset 0x0E returns the mainboard EEPROM data-out on bit 3, with all other bits zero. The data-out input passes through two flip-flops, so a change becomes visible in the read-back two rising edges after it is applied.
- R4: Offsets 0x44 and 0x46 are the EEPROM ports of slots 1 and 2. A write sets chip select from bit 4, clock from bit 2 and data-in from bit 6. A read returns the two-flop-synchronized data-out on bit 7, with all other bits zero.
- R5: A read of offset 0x20 returns 0xFFFF, except that bit 3 is 0 when slot 1 is fitted and bit 11 is 0 when slot 2 is fitted.
- R6: Offset 0x30 is a 16-bit interrupt mask that reads back the last value written to it.
- R7: A read of offset 0x28 returns 0xFFEE and advances a read counter. The read that brings the count to CLEAR_READS (16 by default) clears the network interrupt output and returns the counter to zero.
- R8: A high network interrupt source input sets the interrupt output on the next edge, and this set wins over a clear in the same cycle. With no set and no clearing read, the output holds its value.
- R9: A read of offset 0x3C returns 0xFFFF, except that bit 1 is 0 when the system flash card is fitted and bit 0 is 0 when the slot-0 flash card is fitted.
- R10: The constant words read as follows. Offset 0x3A reads 0x0020, 0x26 reads 0xFFFE, 0x12 reads 0x0007 and 0x40 reads 0x0004. Offsets 0x14, 0x18, 0x2C, 0x2E, 0x48 and 0x4A read 0xFFFF.
- R11: A read of any unmapped offset returns zero. A write to any offset other than the three EEPROM ports and the mask changes no state.
- R12: A synchronous active-low reset clears the following to zero: the mask, the read counter, every EEPROM pin register with its synchronizers, and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset |
| mb_rom_cs | output | 1 | Mainboard EEPROM chip select |
| mb_rom_sk | output | 1 | Mainboard EEPROM serial clock |
| mb_rom_di | output | 1 | Mainboard EEPROM data toward the device |
| mb_rom_do | input | 1 | Mainboard EEPROM data from the device |
| slot_rom_cs | output | NM_SLOTS | Slot EEPROM chip selects |
| slot_rom_sk | output | NM_SLOTS | Slot EEPROM serial clocks |
| slot_rom_di | output | NM_SLOTS | Slot EEPROM data toward the devices |
| slot_rom_do | input | NM_SLOTS | Slot EEPROM data from the devices |
| slot_fitted | input | NM_SLOTS | High when a module is fitted in the slot |
| sys_flash_fitted | input | 1 | High when the system flash card is fitted |
| slot0_flash_fitted | input | 1 | High when the slot-0 flash card is fitted |
| net_irq_set | input | 1 | Network interrupt source |
| net_irq | output | 1 | Network interrupt output |

## Verification
The bench keeps ADDR_W at 8 and NM_SLOTS at 2, but it builds the block with CLEAR_READS set to 5. With that value the interrupt drain wraps after a few status reads, so the bench can test several complete drain periods in a short run. These include a drain that lands in the same cycle as a new set, and a drain cut short by a reset. Both slot ports are instantiated, so the bench can check that their pin bits and read-back stay independent of each other.

// File: rtl/board_io_pkg.sv
// Package: shared word type, register offsets and fixed read values
// for the board I/O register decoder. Assumes byte offsets fit in 8 bits.
package board_io_pkg;
    localparam int DATA_W = 16;
    typedef logic [DATA_W-1:0] word_t;

    localparam logic [7:0] OFS_PLATFORM   = 8'h36;
    localparam logic [7:0] OFS_MB_ROM     = 8'h0E;
    localparam logic [7:0] OFS_SLOT_ROM0  = 8'h44;
    localparam logic [7:0] OFS_PRESENCE   = 8'h20;
    localparam logic [7:0] OFS_IRQ_MASK   = 8'h30;
    localparam logic [7:0] OFS_NET_STAT   = 8'h28;
    localparam logic [7:0] OFS_FLASH      = 8'h3C;
    localparam logic [7:0] OFS_ENV        = 8'h3A;
    localparam logic [7:0] OFS_ONBOARD    = 8'h26;
    localparam logic [7:0] OFS_CARDS      = 8'h12;
    localparam logic [7:0] OFS_CARD_CFG   = 8'h40;
    localparam logic [7:0] OFS_ONES_A     = 8'h14;
    localparam logic [7:0] OFS_ONES_B     = 8'h18;
    localparam logic [7:0] OFS_ONES_C     = 8'h2C;
    localparam logic [7:0] OFS_ONES_D     = 8'h2E;
    localparam logic [7:0] OFS_ONES_E     = 8'h48;
    localparam logic [7:0] OFS_ONES_F     = 8'h4A;

    localparam word_t PLATFORM_WORD = word_t'(4) << 5;
    localparam word_t ENV_WORD      = word_t'(16'h0020);
    localparam word_t ONBOARD_WORD  = word_t'(16'hFFFE);
    localparam word_t CARDS_WORD    = word_t'(16'h0007);
    localparam word_t CARD_CFG_WORD = word_t'(16'h0004);
    localparam word_t NET_STAT_WORD = word_t'(16'hFFEE);

    // Bit positions inside the EEPROM port words (decoded by software).
    localparam int MB_CS_BIT   = 0;
    localparam int MB_SK_BIT   = 1;
    localparam int MB_DI_BIT   = 2;
    localparam int MB_DO_BIT   = 3;
    localparam int SLOT_CS_BIT = 4;
    localparam int SLOT_SK_BIT = 2;
    localparam int SLOT_DI_BIT = 6;
    localparam int SLOT_DO_BIT = 7;

    // Presence bit of slot i is PRES_BASE + PRES_STEP*i.
    localparam int PRES_BASE = 3;
    localparam int PRES_STEP = 8;
endpackage

// File: rtl/bio_rom_port.sv
// bio_rom_port: one bit-banged serial EEPROM port. Holds chip select,
// clock and data-in as registered pins loaded on a write strobe, and
// brings the device's data-out into the clock domain through two flops.
// Assumes the caller has already extracted the three control bits.
module bio_rom_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] ctl_in,   // {cs, sk, di}
    output logic       rom_cs,
    output logic       rom_sk,
    output logic       rom_di,
    input  logic       rom_do,
    output logic       do_sync
);
    logic do_meta;

    // Pin register: load on write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {rom_cs, rom_sk, rom_di} <= 3'b000;
        end else if (wr_en) begin
            {rom_cs, rom_sk, rom_di} <= ctl_in;
        end
    end

    // Two-stage synchronizer for the device data-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            do_meta <= 1'b0;
            do_sync <= 1'b0;
        end else begin
            do_meta <= rom_do;
            do_sync <= do_meta;
        end
    end
endmodule

// File: rtl/bio_irq_drain.sv
// bio_irq_drain: level network interrupt that a source input sets and
// that is dropped after CLEAR_READS reads of the status register.
// Assumes CLEAR_READS >= 2; a set in the same cycle beats the clear.
module bio_irq_drain #(
    parameter int CLEAR_READS = 16,
    parameter int CNT_W       = $clog2(CLEAR_READS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_rd,
    input  logic             irq_set,
    output logic             irq,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAR_READS - 1);

    logic wrap;
    assign wrap = stat_rd && (rd_cnt == LAST);

    // Status-read counter; wraps to zero on the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
        end else if (wrap) begin
            rd_cnt <= '0;
        end else if (stat_rd) begin
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    // Interrupt level: set has priority over the drain clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (irq_set) begin
            irq <= 1'b1;
        end else if (wrap) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/board_io_regs.sv
// board_io_regs: offset decoder for the router board I/O registers.
// Read data is combinational from offset and state; writes land on the
// next edge. Assumes one access per cycle (bus_rd and bus_wr exclusive)
// and quasi-static presence inputs. NM_SLOTS must be 1 or 2 so that the
// presence bits stay inside the 16-bit word.
module board_io_regs
    import board_io_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CLEAR_READS = 16,
    parameter int NM_SLOTS    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                mb_rom_cs,
    output logic                mb_rom_sk,
    output logic                mb_rom_di,
    input  logic                mb_rom_do,
    output logic [NM_SLOTS-1:0] slot_rom_cs,
    output logic [NM_SLOTS-1:0] slot_rom_sk,
    output logic [NM_SLOTS-1:0] slot_rom_di,
    input  logic [NM_SLOTS-1:0] slot_rom_do,
    input  logic [NM_SLOTS-1:0] slot_fitted,
    input  logic                sys_flash_fitted,
    input  logic                slot0_flash_fitted,
    input  logic                net_irq_set,
    output logic                net_irq
);
    localparam int CNT_W = $clog2(CLEAR_READS);

    word_t                     mask_q;
    word_t                     presence_word;
    word_t                     flash_word;
    logic                      mb_do_sync;
    logic [NM_SLOTS-1:0]       slot_do_sync;
    logic [NM_SLOTS-1:0][DATA_W-1:0] slot_word;
    logic [CNT_W-1:0]          drain_cnt;
    logic                      hit_mb;
    logic                      hit_mask;
    logic                      hit_stat;

    assign hit_mb   = (bus_addr == ADDR_W'(OFS_MB_ROM));
    assign hit_mask = (bus_addr == ADDR_W'(OFS_IRQ_MASK));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_NET_STAT));

    // Mainboard EEPROM port.
    bio_rom_port u_mb_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && hit_mb),
        .ctl_in  ({bus_wdata[MB_CS_BIT], bus_wdata[MB_SK_BIT], bus_wdata[MB_DI_BIT]}),
        .rom_cs  (mb_rom_cs),
        .rom_sk  (mb_rom_sk),
        .rom_di  (mb_rom_di),
        .rom_do  (mb_rom_do),
        .do_sync (mb_do_sync)
    );

    // One EEPROM port per module slot, at consecutive half-word offsets.
    for (genvar s = 0; s < NM_SLOTS; s++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_OFS = ADDR_W'(OFS_SLOT_ROM0 + 2 * s);

        bio_rom_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && (bus_addr == SLOT_OFS)),
            .ctl_in  ({bus_wdata[SLOT_CS_BIT], bus_wdata[SLOT_SK_BIT], bus_wdata[SLOT_DI_BIT]}),
            .rom_cs  (slot_rom_cs[s]),
            .rom_sk  (slot_rom_sk[s]),
            .rom_di  (slot_rom_di[s]),
            .rom_do  (slot_rom_do[s]),
            .do_sync (slot_do_sync[s])
        );

        assign slot_word[s] = word_t'(slot_do_sync[s]) << SLOT_DO_BIT;
    end

    // Network interrupt with read-count drain.
    bio_irq_drain #(
        .CLEAR_READS (CLEAR_READS),
        .CNT_W       (CNT_W)
    ) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (bus_rd && hit_stat),
        .irq_set (net_irq_set),
        .irq     (net_irq),
        .rd_cnt  (drain_cnt)
    );

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (bus_wr && hit_mask) begin
            mask_q <= bus_wdata;
        end
    end

    // Active-low presence word for the module slots.
    always_comb begin
        presence_word = '1;
        for (int s = 0; s < NM_SLOTS; s++) begin
            presence_word[PRES_BASE + PRES_STEP * s] = ~slot_fitted[s];
        end
    end

    // Active-low flash card presence word.
    assign flash_word = {{(DATA_W-2){1'b1}}, ~sys_flash_fitted, ~slot0_flash_fitted};

    // Read multiplexer over all decoded offsets.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_PLATFORM): bus_rdata = PLATFORM_WORD;
            ADDR_W'(OFS_MB_ROM):   bus_rdata = word_t'(mb_do_sync) << MB_DO_BIT;
            ADDR_W'(OFS_PRESENCE): bus_rdata = presence_word;
            ADDR_W'(OFS_IRQ_MASK): bus_rdata = mask_q;
            ADDR_W'(OFS_NET_STAT): bus_rdata = NET_STAT_WORD;
            ADDR_W'(OFS_FLASH):    bus_rdata = flash_word;
            ADDR_W'(OFS_ENV):      bus_rdata = ENV_WORD;
            ADDR_W'(OFS_ONBOARD):  bus_rdata = ONBOARD_WORD;
            ADDR_W'(OFS_CARDS):    bus_rdata = CARDS_WORD;
            ADDR_W'(OFS_CARD_CFG): bus_rdata = CARD_CFG_WORD;
            ADDR_W'(OFS_ONES_A), ADDR_W'(OFS_ONES_B), ADDR_W'(OFS_ONES_C),
            ADDR_W'(OFS_ONES_D), ADDR_W'(OFS_ONES_E), ADDR_W'(OFS_ONES_F):
                                   bus_rdata = '1;
            default:               bus_rdata = '0;
        endcase
        for (int s = 0; s < NM_SLOTS; s++) begin
            if (bus_addr == ADDR_W'(OFS_SLOT_ROM0 + 2 * s)) begin
                bus_rdata = slot_word[s];
            end
        end
    end
endmodule

// File: rtl/board_io_regs_chk.sv
// board_io_regs_chk: temporal checks on the decoder's ports and state,
// attached to every board_io_regs instance by the bind below.
module board_io_regs_chk
    import board_io_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CLEAR_READS = 16,
    parameter int CNT_W       = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              mb_rom_cs,
    input logic              mb_rom_sk,
    input logic              mb_rom_di,
    input logic              net_irq_set,
    input logic              net_irq,
    input logic [DATA_W-1:0] mask_q,
    input logic [CNT_W-1:0]  drain_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAR_READS - 1);

    logic stat_rd;
    assign stat_rd = bus_rd && (bus_addr == ADDR_W'(OFS_NET_STAT));

    p_platform_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_PLATFORM)) |-> (bus_rdata == 16'h0080));

    p_mb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_MB_ROM)) |=> $stable({mb_rom_cs, mb_rom_sk, mb_rom_di}));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_IRQ_MASK)) |=> $stable(mask_q));

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drain_cnt <= LAST);

    p_drain_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && drain_cnt == LAST && !net_irq_set) |=> (!net_irq && drain_cnt == '0));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        net_irq_set |=> net_irq);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!net_irq_set && !stat_rd) |=> $stable(net_irq));
endmodule

bind board_io_regs board_io_regs_chk #(
    .ADDR_W      (ADDR_W),
    .CLEAR_READS (CLEAR_READS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .mb_rom_cs   (mb_rom_cs),
    .mb_rom_sk   (mb_rom_sk),
    .mb_rom_di   (mb_rom_di),
    .net_irq_set (net_irq_set),
    .net_irq     (net_irq),
    .mask_q      (mask_q),
    .drain_cnt   (drain_cnt)
);

// File: tb/board_io_regs_test.sv
// board_io_regs_test: directed stimulus plus a behavioural reference
// model compared on every clock. Built with CLEAR_READS = 5.
module board_io_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int CR         = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        mb_rom_cs, mb_rom_sk, mb_rom_di;
    logic        mb_rom_do = 1'b0;
    logic [1:0]  slot_rom_cs, slot_rom_sk, slot_rom_di;
    logic [1:0]  slot_rom_do = 2'b00;
    logic [1:0]  slot_fitted = 2'b00;
    logic        sys_flash_fitted = 1'b0;
    logic        slot0_flash_fitted = 1'b0;
    logic        net_irq_set = 1'b0;
    logic        net_irq;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    board_io_regs #(.ADDR_W(8), .CLEAR_READS(CR), .NM_SLOTS(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mb_rom_cs(mb_rom_cs), .mb_rom_sk(mb_rom_sk), .mb_rom_di(mb_rom_di),
        .mb_rom_do(mb_rom_do), .slot_rom_cs(slot_rom_cs), .slot_rom_sk(slot_rom_sk),
        .slot_rom_di(slot_rom_di), .slot_rom_do(slot_rom_do), .slot_fitted(slot_fitted),
        .sys_flash_fitted(sys_flash_fitted), .slot0_flash_fitted(slot0_flash_fitted),
        .net_irq_set(net_irq_set), .net_irq(net_irq)
    );

    // Reference model state.
    logic [15:0] m_mask = 0;
    int          m_cnt = 0;
    logic        m_irq = 0;
    logic [2:0]  m_mb = 0;
    logic [2:0]  m_slot [2] = '{3'b0, 3'b0};
    logic        m_mb_s1 = 0, m_mb_s2 = 0;
    logic [1:0]  m_sl_s1 = 0, m_sl_s2 = 0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 0; m_cnt = 0; m_irq = 0; m_mb = 0;
            m_slot[0] = 0; m_slot[1] = 0;
            m_mb_s1 = 0; m_mb_s2 = 0; m_sl_s1 = 0; m_sl_s2 = 0;
        end else begin
            bit clr;
            clr = 0;
            m_mb_s2 = m_mb_s1; m_mb_s1 = mb_rom_do;
            m_sl_s2 = m_sl_s1; m_sl_s1 = slot_rom_do;
            if (bus_wr) begin
                case (bus_addr)
                    8'h0E: m_mb = {bus_wdata[0], bus_wdata[1], bus_wdata[2]};
                    8'h44: m_slot[0] = {bus_wdata[4], bus_wdata[2], bus_wdata[6]};
                    8'h46: m_slot[1] = {bus_wdata[4], bus_wdata[2], bus_wdata[6]};
                    8'h30: m_mask = bus_wdata;
                    default: ;
                endcase
            end
            if (bus_rd && bus_addr == 8'h28) begin
                m_cnt++;
                if (m_cnt == CR) begin
                    m_cnt = 0;
                    clr = 1;
                end
            end
            if (net_irq_set) m_irq = 1;
            else if (clr) m_irq = 0;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        logic [15:0] v;
        case (a)
            8'h36: v = 16'h0080;
            8'h0E: v = {12'h0, m_mb_s2, 3'b000};
            8'h44: v = {8'h0, m_sl_s2[0], 7'b0};
            8'h46: v = {8'h0, m_sl_s2[1], 7'b0};
            8'h20: begin
                v = 16'hFFFF;
                if (slot_fitted[0]) v[3] = 1'b0;
                if (slot_fitted[1]) v[11] = 1'b0;
            end
            8'h30: v = m_mask;
            8'h28: v = 16'hFFEE;
            8'h3C: v = {14'h3FFF, ~sys_flash_fitted, ~slot0_flash_fitted};
            8'h3A: v = 16'h0020;
            8'h26: v = 16'hFFFE;
            8'h12: v = 16'h0007;
            8'h40: v = 16'h0004;
            8'h14, 8'h18, 8'h2C, 8'h2E, 8'h48, 8'h4A: v = 16'hFFFF;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h36: return "R1";
            8'h0E: return "R3";
            8'h44, 8'h46: return "R4";
            8'h20: return "R5";
            8'h30: return "R6";
            8'h28: return "R7";
            8'h3C: return "R9";
            8'h3A, 8'h26, 8'h12, 8'h40, 8'h14, 8'h18, 8'h2C, 8'h2E, 8'h48, 8'h4A: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #2;
        if (cmp_on) begin
            chk(rst_n ? "R2" : "R12", {13'h0, mb_rom_cs, mb_rom_sk, mb_rom_di}, {13'h0, m_mb});
            chk(rst_n ? "R4" : "R12", {10'h0, slot_rom_cs, slot_rom_sk, slot_rom_di},
                {10'h0, m_slot[1][2], m_slot[0][2], m_slot[1][1], m_slot[0][1],
                 m_slot[1][0], m_slot[0][0]});
            chk(rst_n ? "R8" : "R12", {15'h0, net_irq}, {15'h0, m_irq});
            if (bus_rd) chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 8'h00, 16'h0);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 16'h0);
        #3;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;
        #3;
        // R12: reset state
        chk("R12", {13'h0, mb_rom_cs, mb_rom_sk, mb_rom_di}, 16'h0);
        chk("R12", {15'h0, net_irq}, 16'h0);
        rd_chk(8'h30, 16'h0000, "R12");
        @(negedge clk); rst_n = 1'b1;
        idle();

        // R1, R10, R7 constants; R11 unmapped
        rd_chk(8'h36, 16'h0080, "R1");
        rd_chk(8'h3A, 16'h0020, "R10");
        rd_chk(8'h26, 16'hFFFE, "R10");
        rd_chk(8'h12, 16'h0007, "R10");
        rd_chk(8'h40, 16'h0004, "R10");
        rd_chk(8'h14, 16'hFFFF, "R10");
        rd_chk(8'h4A, 16'hFFFF, "R10");
        rd_chk(8'h2E, 16'hFFFF, "R10");
        rd_chk(8'h28, 16'hFFEE, "R7");
        rd_chk(8'h00, 16'h0000, "R11");
        rd_chk(8'h22, 16'h0000, "R11");
        rd_chk(8'hFF, 16'h0000, "R11");
        rd_chk(8'h45, 16'h0000, "R11");

        // R6: mask read-back
        cyc(1'b1, 1'b0, 8'h30, 16'hA5C3);
        rd_chk(8'h30, 16'hA5C3, "R6");
        cyc(1'b1, 1'b0, 8'h30, 16'h1234);
        idle();
        rd_chk(8'h30, 16'h1234, "R6");

        // R2: mainboard pins
        cyc(1'b1, 1'b0, 8'h0E, 16'hFFF5);
        idle(); #3;
        chk("R2", {13'h0, mb_rom_cs, mb_rom_sk, mb_rom_di}, 16'h0005);
        idle(); idle(); #3;
        chk("R2", {13'h0, mb_rom_cs, mb_rom_sk, mb_rom_di}, 16'h0005);
        cyc(1'b1, 1'b0, 8'h0E, 16'h0002);
        idle(); #3;
        chk("R2", {13'h0, mb_rom_cs, mb_rom_sk, mb_rom_di}, 16'h0002);

        // R3: data-out two-edge latency
        @(negedge clk); mb_rom_do = 1'b1; bus_wr = 0; bus_rd = 0;
        rd_chk(8'h0E, 16'h0000, "R3");
        rd_chk(8'h0E, 16'h0008, "R3");

        // R4: slot ports
        cyc(1'b1, 1'b0, 8'h44, 16'h0054);
        cyc(1'b1, 1'b0, 8'h46, 16'h0010);
        idle(); #3;
        chk("R4", {13'h0, slot_rom_cs[0], slot_rom_sk[0], slot_rom_di[0]}, 16'h0007);
        chk("R4", {13'h0, slot_rom_cs[1], slot_rom_sk[1], slot_rom_di[1]}, 16'h0004);
        @(negedge clk); slot_rom_do = 2'b10;
        idle(); idle();
        rd_chk(8'h46, 16'h0080, "R4");
        rd_chk(8'h44, 16'h0000, "R4");

        // R5: slot presence
        slot_fitted = 2'b01; rd_chk(8'h20, 16'hFFF7, "R5");
        slot_fitted = 2'b10; rd_chk(8'h20, 16'hF7FF, "R5");
        slot_fitted = 2'b11; rd_chk(8'h20, 16'hF7F7, "R5");
        slot_fitted = 2'b00; rd_chk(8'h20, 16'hFFFF, "R5");

        // R9: flash presence
        sys_flash_fitted = 1; rd_chk(8'h3C, 16'hFFFD, "R9");
        sys_flash_fitted = 0; slot0_flash_fitted = 1; rd_chk(8'h3C, 16'hFFFE, "R9");
        sys_flash_fitted = 1; rd_chk(8'h3C, 16'hFFFC, "R9");

        // R11: ignored writes
        cyc(1'b1, 1'b0, 8'h36, 16'hFFFF);
        cyc(1'b1, 1'b0, 8'h20, 16'h0000);
        cyc(1'b1, 1'b0, 8'h28, 16'hFFFF);
        cyc(1'b1, 1'b0, 8'h00, 16'hFFFF);
        cyc(1'b1, 1'b0, 8'h31, 16'hFFFF);
        idle(); #3;
        chk("R11", {13'h0, mb_rom_cs, mb_rom_sk, mb_rom_di}, 16'h0002);
        chk("R11", {15'h0, net_irq}, 16'h0);
        rd_chk(8'h30, 16'h1234, "R11");
        rd_chk(8'h36, 16'h0080, "R11");

        // R12: reset mid-run clears mask, pins and counter
        @(negedge clk); rst_n = 1'b0; bus_rd = 0; bus_wr = 0;
        idle(); #3;
        chk("R12", {13'h0, mb_rom_cs, mb_rom_sk, mb_rom_di}, 16'h0);
        chk("R12", {10'h0, slot_rom_cs, slot_rom_sk, slot_rom_di}, 16'h0);
        rd_chk(8'h30, 16'h0000, "R12");
        @(negedge clk); rst_n = 1'b1;
        idle();

        // R8 / R7: interrupt set and drain
        @(negedge clk); net_irq_set = 1;
        @(negedge clk); net_irq_set = 0; #3;
        chk("R8", {15'h0, net_irq}, 16'h1);
        for (int i = 0; i < CR - 1; i++) rd_chk(8'h28, 16'hFFEE, "R7");
        idle(); #3;
        chk("R7", {15'h0, net_irq}, 16'h1);
        rd_chk(8'h28, 16'hFFEE, "R7");
        idle(); #3;
        chk("R7", {15'h0, net_irq}, 16'h0);

        // R8: set wins over clearing read
        @(negedge clk); net_irq_set = 1;
        @(negedge clk); net_irq_set = 0;
        for (int i = 0; i < CR - 1; i++) rd_chk(8'h28, 16'hFFEE, "R7");
        @(negedge clk); net_irq_set = 1; bus_rd = 1; bus_addr = 8'h28;
        @(negedge clk); net_irq_set = 0; bus_rd = 0; #3;
        chk("R8", {15'h0, net_irq}, 16'h1);
        rd_chk(8'h28, 16'hFFEE, "R8");
        idle(); idle(); #3;
        chk("R8", {15'h0, net_irq}, 16'h1);

        repeat (3) idle();
        summary();
        $finish;
    end
endmodule